// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer. Its write port and its read port each run on their own clock. The two clocks may be one net or fully unrelated. Each port moves at most one word per rising edge of its clock, and only while its enable is high.

The read and write pointers carry one wrap bit. They cross between the clock domains as Gray code through two-flop synchronizers. The write side produces full, almost-full and half-full. The read side produces empty and almost-empty.

The two almost thresholds are offsets held in registers. Reset sets both to 7 words. A small load port can replace either offset, but only while the buffer is idle. An output enable gates the read data bus.

Top module: `pf_fifo`

## Requirements
- R1: Accepted words come out of `rdata_o` in the order they were written, with all 18 bits intact. `rdata_o` takes the next word on the read-clock edge that accepts a read.
- R2: A write with `full_o` high is ignored. The write pointer does not move and no stored word changes.
- R3: A read with `empty_o` high is ignored. The read pointer does not move and `rdata_o` keeps its previous value.
- R4: Reset gives `empty_o`=1, `full_o`=0, `almost_empty_o`=1, `almost_full_o`=0 and `half_full_o`=0. After settling, `empty_o` is high exactly when the fill level is 0, and `full_o` is high exactly when the fill level is DEPTH.
- R5: `almost_empty_o` is high when the fill level is at or below the almost-empty offset. The default offset is 7.
- R6: `almost_full_o` is high when DEPTH minus the fill level is at or below the almost-full offset. The default offset is 7.
- R7: `half_full_o` is high when the fill level is greater than DEPTH/2.
- R8: A write-clock edge with `cfg_we_i`=1 loads `cfg_val_i` into an offset register. `cfg_sel_i`=0 selects the almost-empty offset and `cfg_sel_i`=1 selects the almost-full offset. The load takes effect only when the buffer is empty and `wen_i`=0. Otherwise it is ignored.
- R9: While `oe_i`=0, `rdata_o` reads all zeros. Raising `oe_i` again shows the held word.
- R10: With unrelated read and write clocks, every written word is read back once and in order.
- R11: Reset returns both offsets to the default of 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock, may be the same net as wclk_i |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wen_i | input | 1 | Write enable |
| wdata_i | input | DW (18) | Write data |
| ren_i | input | 1 | Read enable |
| oe_i | input | 1 | Output enable for rdata_o |
| cfg_we_i | input | 1 | Offset load strobe (write domain) |
| cfg_sel_i | input | 1 | 0 = almost-empty offset, 1 = almost-full offset |
| cfg_val_i | input | log2(DEPTH) | Offset value to load |
| rdata_o | output | DW (18) | Read data, zero while oe_i is low |
| empty_o | output | 1 | Empty flag (read domain) |
| almost_empty_o | output | 1 | Almost-empty flag (read domain) |
| full_o | output | 1 | Full flag (write domain) |
| almost_full_o | output | 1 | Almost-full flag (write domain) |
| half_full_o | output | 1 | Half-full flag (write domain) |

## Verification
The bench probes every flag at both sides of its threshold: fill levels 7/8, DEPTH/2 and DEPTH/2+1, and DEPTH-8/DEPTH-7. An off-by-one compare in any flag shows up there as a wrong flag value.

It pushes one extra word into a full buffer and pulls from an empty one. A design without those guards would wrap its pointer and report empty, or would change `rdata_o`.

Offset loads are tried both while idle and while holding data. A load that is wrongly accepted moves the almost-empty edge at fill level 50. Reset is then checked to restore the default offsets.

Random traffic on tied clocks, and a burst on unrelated clocks, compare every word read against a reference queue. A broken Gray conversion or synchronizer would drop, repeat or reorder words.

// File: rtl/pf_fifo_pkg.sv
package pf_fifo_pkg;
  localparam int unsigned DEF_OFFSET = 7;
  typedef enum logic {OFF_AE = 1'b0, OFF_AF = 1'b1} off_sel_e;
endpackage

// File: rtl/pf_fifo_ptr.sv
module pf_fifo_ptr #(
  parameter int PW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [PW-1:0] bin_o,
  output logic [PW-1:0] gray_o
);
  logic [PW-1:0] bin_nx;
  assign bin_nx = bin_o + PW'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_o  <= '0;
      gray_o <= '0;
    end else begin
      bin_o  <= bin_nx;
      gray_o <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/pf_fifo_gsync.sv
module pf_fifo_gsync #(
  parameter int PW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);
  logic [PW-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  // gray to binary: bit i is the xor of all gray bits at and above i
  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign bin_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/pf_fifo_ram.sv
module pf_fifo_ram #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int N = 1 << AW;
  logic [DW-1:0] mem_q [N];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/pf_fifo.sv
module pf_fifo
  import pf_fifo_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int DW      = 18,
  parameter int DEF_OFF = DEF_OFFSET,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wen_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_i,
  input  logic          oe_i,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [AW-1:0] cfg_val_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          almost_empty_o,
  output logic          full_o,
  output logic          almost_full_o,
  output logic          half_full_o
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rbin_w, wbin_r, wcount, rcount;
  logic [AW-1:0] ae_off_q, af_off_q;
  logic [DW-1:0] rd_q;
  logic          wr_acc, rd_acc;

  assign wr_acc = wen_i & ~full_o;
  assign rd_acc = ren_i & ~empty_o;

  pf_fifo_ptr #(.PW(PW)) i_wptr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .inc_i(wr_acc), .bin_o(wbin_q), .gray_o(wgray_q));
  pf_fifo_ptr #(.PW(PW)) i_rptr (
    .clk_i(rclk_i), .rst_ni(rst_ni), .inc_i(rd_acc), .bin_o(rbin_q), .gray_o(rgray_q));

  pf_fifo_gsync #(.PW(PW)) i_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rgray_q), .bin_o(rbin_w));
  pf_fifo_gsync #(.PW(PW)) i_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wgray_q), .bin_o(wbin_r));

  pf_fifo_ram #(.DW(DW), .AW(AW)) i_ram (
    .wclk_i(wclk_i), .we_i(wr_acc), .waddr_i(wbin_q[AW-1:0]), .wdata_i(wdata_i),
    .rclk_i(rclk_i), .rst_ni(rst_ni), .re_i(rd_acc), .raddr_i(rbin_q[AW-1:0]),
    .rdata_o(rd_q));

  // write-domain level and flags
  assign wcount        = wbin_q - rbin_w;
  assign full_o        = (wcount == DEPTH_P);
  assign almost_full_o = ((DEPTH_P - wcount) <= {1'b0, af_off_q});
  assign half_full_o   = (wcount > HALF_P);

  // read-domain level and flags
  assign rcount         = wbin_r - rbin_q;
  assign empty_o        = (rcount == '0);
  assign almost_empty_o = (rcount <= {1'b0, ae_off_q});

  // offsets change only while idle, so the read side sees a quasi-static value
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_off_q <= AW'(DEF_OFF);
      af_off_q <= AW'(DEF_OFF);
    end else if (cfg_we_i && !wen_i && wcount == '0) begin
      if (cfg_sel_i == OFF_AF) af_off_q <= cfg_val_i;
      else                     ae_off_q <= cfg_val_i;
    end
  end

  assign rdata_o = oe_i ? rd_q : '0;
endmodule

// File: rtl/pf_fifo_chk.sv
module pf_fifo_chk #(
  parameter int PW = 9,
  parameter int DW = 18
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wen_i,
  input logic          ren_i,
  input logic          oe_i,
  input logic          full_o,
  input logic          empty_o,
  input logic          almost_full_o,
  input logic          almost_empty_o,
  input logic          half_full_o,
  input logic [DW-1:0] rdata_o,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin
);
  a_r2_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o && wen_i |=> $stable(wbin));
  a_r1_write_step: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wen_i && !full_o |=> wbin == $past(wbin) + PW'(1));
  a_r3_no_underflow: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o && ren_i |=> $stable(rbin));
  a_r1_read_step: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ren_i && !empty_o |=> rbin == $past(rbin) + PW'(1));
  a_r4_full_implies: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> almost_full_o && half_full_o);
  a_r4_empty_implies: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o |-> almost_empty_o);
  a_r9_oe_gate: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !oe_i |-> rdata_o == '0);
endmodule

bind pf_fifo pf_fifo_chk #(.PW($clog2(DEPTH) + 1), .DW(DW)) i_pf_fifo_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .wen_i(wen_i), .ren_i(ren_i),
  .oe_i(oe_i), .full_o(full_o), .empty_o(empty_o), .almost_full_o(almost_full_o),
  .almost_empty_o(almost_empty_o), .half_full_o(half_full_o), .rdata_o(rdata_o),
  .wbin(wbin_q), .rbin(rbin_q));

// File: tb/test_pf_fifo.sv
`timescale 1ns/1ps
module test_pf_fifo;
  localparam int DEPTH = 256;
  localparam int DW    = 18;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0, clk_b = 1'b0, async_m = 1'b0;
  logic rst_ni = 1'b0;
  logic wen_i = 0, ren_i = 0, oe_i = 1, cfg_we_i = 0, cfg_sel_i = 0;
  logic [DW-1:0] wdata_i = '0;
  logic [AW-1:0] cfg_val_i = '0;
  logic [DW-1:0] rdata_o;
  logic empty_o, almost_empty_o, full_o, almost_full_o, half_full_o;
  logic rclk;

  always #4 clk = ~clk;
  always #5.5 clk_b = ~clk_b;
  assign rclk = async_m ? clk_b : clk;

  pf_fifo #(.DEPTH(DEPTH), .DW(DW)) i_pf_fifo (
    .wclk_i(clk), .rclk_i(rclk), .rst_ni(rst_ni), .wen_i(wen_i), .wdata_i(wdata_i),
    .ren_i(ren_i), .oe_i(oe_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_val_i(cfg_val_i), .rdata_o(rdata_o), .empty_o(empty_o),
    .almost_empty_o(almost_empty_o), .full_o(full_o), .almost_full_o(almost_full_o),
    .half_full_o(half_full_o));

  int n_chk = 0, n_fail = 0;
  int ae_exp = 7, af_exp = 7;
  int wr_seq = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] last_rd = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int k);
    return DW'((k * 32'h9E37) ^ (k << 11) ^ 32'h15A5);
  endfunction

  // {empty, almost_empty, half_full, almost_full, full}
  function automatic logic [4:0] exp_flags(input int n);
    return {n == 0, n <= ae_exp, n > DEPTH / 2, (DEPTH - n) <= af_exp, n == DEPTH};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; wen_i = 0; ren_i = 0; cfg_we_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    q.delete(); last_rd = '0; ae_exp = 7; af_exp = 7;
  endtask

  // one tied-clock cycle; entered and left at a negedge of clk
  task automatic cyc(input bit w, input logic [DW-1:0] d, input bit r, input string req);
    bit w_ok, r_ok;
    wen_i = w; wdata_i = d; ren_i = r;
    w_ok = w && !full_o;
    r_ok = r && !empty_o;
    @(posedge clk);
    @(negedge clk);
    if (r_ok) begin
      logic [DW-1:0] e;
      e = q.pop_front();
      check(rdata_o == e, req, int'(rdata_o), int'(e));
      last_rd = e;
    end
    if (w_ok) q.push_back(d);
    wen_i = 0; ren_i = 0;
  endtask

  task automatic settle();
    repeat (4) cyc(0, '0, 0, "idle");
  endtask

  task automatic flags(input string req);
    logic [4:0] a, e;
    settle();
    a = {empty_o, almost_empty_o, half_full_o, almost_full_o, full_o};
    e = exp_flags(q.size());
    check(a == e, req, int'(a), int'(e));
  endtask

  task automatic fill_to(input int n);
    while (q.size() < n) begin
      wr_seq++;
      cyc(1, pat(wr_seq), 0, "R1 fill");
    end
  endtask

  task automatic drain(input string req);
    while (q.size() > 0) cyc(0, '0, 1, req);
  endtask

  task automatic load(input bit sel, input int v);
    @(negedge clk);
    cfg_we_i = 1; cfg_sel_i = sel; cfg_val_i = AW'(v);
    @(posedge clk);
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  initial begin
    #1_200_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    @(negedge clk);
    check({empty_o, almost_empty_o, half_full_o, almost_full_o, full_o} == 5'b11000,
          "R4 reset flags", int'({empty_o, almost_empty_o, half_full_o, almost_full_o, full_o}), 'h18);

    fill_to(7);          flags("R5 ae at offset 7");
    fill_to(8);          flags("R5 ae above offset");
    fill_to(DEPTH / 2);  flags("R7 hf at half");
    fill_to(DEPTH/2 + 1); flags("R7 hf above half");
    fill_to(DEPTH - 8);  flags("R6 af below");
    fill_to(DEPTH - 7);  flags("R6 af at offset");
    fill_to(DEPTH);      flags("R4 full");

    cyc(1, 18'h3FFFF, 0, "R2 write while full");
    flags("R2 full after extra write");
    drain("R2 R1 drain order");
    flags("R4 empty after drain");

    cyc(0, '0, 1, "R3 read while empty");
    check(rdata_o == last_rd, "R3 rdata held", int'(rdata_o), int'(last_rd));
    flags("R3 still empty");
    cyc(1, 18'h2A5A5, 0, "R1 single");
    settle();
    cyc(0, '0, 1, "R1 single word");

    // R9 output enable
    oe_i = 0;
    #1 check(rdata_o == '0, "R9 oe low", int'(rdata_o), 0);
    @(negedge clk); oe_i = 1;
    #1 check(rdata_o == 18'h2A5A5, "R9 oe restore", int'(rdata_o), 'h2A5A5);

    // R8 offset loads
    settle();
    load(0, 20); ae_exp = 20;
    fill_to(20); flags("R8 ae offset 20 at 20");
    fill_to(21); flags("R8 ae offset 20 at 21");
    load(0, 100);        // ignored: not empty
    fill_to(50); flags("R8 ignored load while busy");
    drain("R1 drain");
    settle();
    load(1, 3); af_exp = 3;
    fill_to(DEPTH - 4); flags("R8 af offset 3 at D-4");
    fill_to(DEPTH - 3); flags("R8 af offset 3 at D-3");

    // R11 reset restores defaults
    do_reset();
    fill_to(8); flags("R11 default ae after reset");
    fill_to(DEPTH - 7); flags("R11 default af after reset");
    drain("R1 drain");

    // random tied-clock traffic
    for (int i = 0; i < 3000; i++) begin
      bit w, r;
      w = ($urandom % 100) < 55;
      r = ($urandom % 100) < 50;
      cyc(w, DW'($urandom), r, "R1 random order");
      if (i % 500 == 499) flags("R4 R5 R6 R7 random settle");
    end
    drain("R1 random drain");
    flags("R4 empty after random");

    // R10 unrelated clocks
    async_m = 1;
    do_reset();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 40; i++) cyc(1, pat(1000 + i), 0, "R10 write");
    begin
      int got = 0;
      for (int k = 0; k < 400 && q.size() > 0; k++) begin
        bit r_ok;
        @(negedge clk_b);
        ren_i = !empty_o;
        r_ok = !empty_o;
        @(negedge clk_b);
        ren_i = 0;
        if (r_ok) begin
          logic [DW-1:0] e;
          e = q.pop_front();
          got++;
          check(rdata_o == e, "R10 async order", int'(rdata_o), int'(e));
        end
      end
      check(got == 40, "R10 async count", got, 40);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule